// File: doc/BRIEF.md
# Packed Elapsed-Time Counter (hours, minutes, seconds, 1/128 s)

This block keeps elapsed time as four cascaded fields packed into one 32-bit word. The lowest field counts 1/128-second steps. It advances once for every qualified tick. A tick is a one-cycle pulse at 128 Hz, which is a 32768 Hz reference divided by 256; the divider lives outside this block. When a field passes its top value it returns to zero, and the next field up advances in the same clock edge. Seconds and minutes run 0 to 59. Hours run 0 to 23 or 0 to 255, chosen by a control input.

Software can preload the counter with a word in the same packed layout. On load, reserved bits are discarded and any field above its range is clamped to its top value. The packed time is always visible on a registered output, with the reserved gaps held at zero. A full rollover of the hour field raises a sticky interrupt flag, which stays up until it is cleared.

Top module: `hms_time_counter`

## Requirements
- R1: The fraction field sits in bits [6:0]. It counts 0 to 127 by one per qualified tick, and after 127 it returns to 0 and carries into seconds.
- R2: The seconds field sits in bits [13:8]. It never exceeds 59, and after 59 it returns to 0 on a carry and carries into minutes.
- R3: The minutes field sits in bits [21:16]. It never exceeds 59, and after 59 it returns to 0 on a carry and carries into hours.
- R4: The hours field sits in bits [31:24]. Its limit is 23 when `hour_mode_24`=1 and 255 when it is 0. On a carry, an hour value at or above the limit returns to 0; any other hour value advances by 1.
- R5: Bits 7, [15:14] and [23:22] of `time_q` always read zero.
- R6: The counter advances only in a cycle with `en`=1 and `tick`=1; in any other cycle without a load, `time_q` holds its value.
- R7: With `load`=1, `load_word` replaces the time on the next edge, whatever `en` and `tick` are. Reserved bits are dropped, seconds and minutes above 59 become 59, and hours above the current hour limit become that limit.
- R8: `wrap_irq` goes to 1 on the edge where the hour field wraps to 0 on a carry. It stays at 1 until an edge with `irq_clr`=1 and no wrap; a wrap in the same cycle as a clear wins.
- R9: Synchronous reset `rst`=1 sets `time_q` to 0 and `wrap_irq` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Counting enable |
| tick | input | 1 | One-cycle 128 Hz step pulse |
| hour_mode_24 | input | 1 | 1: hours wrap after 23; 0: hours wrap after 255 |
| load | input | 1 | Load strobe; has priority over a tick |
| load_word | input | 32 | Packed time to load |
| irq_clr | input | 1 | Clears the wrap flag |
| time_q | output | 32 | Packed current time (registered) |
| wrap_irq | output | 1 | Sticky hour-wrap flag |

## Verification
The assertions check on every cycle that the reserved bits are zero and that seconds and minutes stay in range. They also check that `time_q` holds without a qualified tick or load, that the fraction advances by one per qualified tick, that a load lands in the fraction field, and that the flag rises only after a qualified tick. The bench scenarios cover the rest: the carry chain through every field, clamping of out-of-range loads, both hour limits, and an hour value left above the limit after a mode change. They also cover load-over-tick priority and the precedence of a wrap over a clear in the same cycle. A behavioural reference model is compared against every output field on every clock, across directed and pseudo-random stimulus.

// File: rtl/hms_pkg.sv
package hms_pkg;
  localparam int WORD_W   = 32;
  localparam int FRAC_W   = 7;
  localparam int SEC_W    = 6;
  localparam int MIN_W    = 6;
  localparam int HOUR_W   = 8;
  localparam int FRAC_LSB = 0;
  localparam int SEC_LSB  = 8;
  localparam int MIN_LSB  = 16;
  localparam int HOUR_LSB = 24;
  localparam int FRAC_TOP = 127;
  localparam int SEC_TOP  = 59;
  localparam int MIN_TOP  = 59;
  localparam int HOUR_TOP_DAY  = 23;
  localparam int HOUR_TOP_FULL = 255;

  typedef struct packed {
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
    logic [FRAC_W-1:0] frac;
  } hms_t;

  function automatic logic [WORD_W-1:0] hms_pack(input hms_t t);
    logic [WORD_W-1:0] w;
    w = '0;
    w[FRAC_LSB +: FRAC_W] = t.frac;
    w[SEC_LSB  +: SEC_W]  = t.sec;
    w[MIN_LSB  +: MIN_W]  = t.min;
    w[HOUR_LSB +: HOUR_W] = t.hour;
    return w;
  endfunction

  function automatic hms_t hms_unpack(input logic [WORD_W-1:0] w);
    hms_t t;
    t.frac = w[FRAC_LSB +: FRAC_W];
    t.sec  = w[SEC_LSB  +: SEC_W];
    t.min  = w[MIN_LSB  +: MIN_W];
    t.hour = w[HOUR_LSB +: HOUR_W];
    return t;
  endfunction
endpackage

// File: rtl/hms_field.sv
// One cascaded time field: load with clamp, step with wrap, carry out.
module hms_field #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic [W-1:0] lim,
  output logic [W-1:0] val,
  output logic         carry
);
  logic at_top;
  logic [W-1:0] clamped;

  assign at_top  = (val >= lim);
  assign carry   = step && at_top;
  assign clamped = (load_val > lim) ? lim : load_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      val <= '0;
    end else if (load) begin
      val <= clamped;
    end else if (step) begin
      val <= at_top ? '0 : val + W'(1);
    end
  end
endmodule

// File: rtl/hms_irq_flag.sv
// Sticky flag: a set on the same edge as a clear wins.
module hms_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/hms_time_counter.sv
module hms_time_counter
  import hms_pkg::*;
#(
  parameter int WIDTH = hms_pkg::WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             hour_mode_24,
  input  logic             load,
  input  logic [WIDTH-1:0] load_word,
  input  logic             irq_clr,
  output logic [WIDTH-1:0] time_q,
  output logic             wrap_irq
);
  localparam int NF = 4;

  hms_t ld;
  hms_t cur;
  logic [NF:0] chain;
  logic [HOUR_W-1:0] hour_lim;

  assign ld       = hms_unpack(load_word);
  assign hour_lim = hour_mode_24 ? HOUR_W'(HOUR_TOP_DAY) : HOUR_W'(HOUR_TOP_FULL);
  assign chain[0] = en && tick && !load;

  hms_field #(.W(FRAC_W)) u_frac (
    .clk(clk), .rst(rst), .load(load), .load_val(ld.frac),
    .step(chain[0]), .lim(FRAC_W'(FRAC_TOP)), .val(cur.frac), .carry(chain[1])
  );
  hms_field #(.W(SEC_W)) u_sec (
    .clk(clk), .rst(rst), .load(load), .load_val(ld.sec),
    .step(chain[1]), .lim(SEC_W'(SEC_TOP)), .val(cur.sec), .carry(chain[2])
  );
  hms_field #(.W(MIN_W)) u_min (
    .clk(clk), .rst(rst), .load(load), .load_val(ld.min),
    .step(chain[2]), .lim(MIN_W'(MIN_TOP)), .val(cur.min), .carry(chain[3])
  );
  hms_field #(.W(HOUR_W)) u_hour (
    .clk(clk), .rst(rst), .load(load), .load_val(ld.hour),
    .step(chain[3]), .lim(hour_lim), .val(cur.hour), .carry(chain[4])
  );

  hms_irq_flag u_flag (
    .clk(clk), .rst(rst), .set(chain[NF]), .clr(irq_clr), .flag(wrap_irq)
  );

  assign time_q = hms_pack(cur);
endmodule

// File: rtl/hms_time_counter_chk.sv
module hms_time_counter_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             tick,
  input logic             hour_mode_24,
  input logic             load,
  input logic [WIDTH-1:0] load_word,
  input logic             irq_clr,
  input logic [WIDTH-1:0] time_q,
  input logic             wrap_irq
);
  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (time_q[7] == 1'b0) && (time_q[15:14] == 2'b00) && (time_q[23:22] == 2'b00));
  // R2
  sec_range_chk: assert property (@(posedge clk) disable iff (rst)
    time_q[13:8] <= 6'd59);
  // R3
  min_range_chk: assert property (@(posedge clk) disable iff (rst)
    time_q[21:16] <= 6'd59);
  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !(en && tick)) |=> $stable(time_q));
  // R1
  frac_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !load) |=> (time_q[6:0] == $past(time_q[6:0]) + 7'd1));
  // R7
  load_frac_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (time_q[6:0] == $past(load_word[6:0])));
  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wrap_irq) |-> $past(en && tick && !load));
endmodule

bind hms_time_counter hms_time_counter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/hms_time_counter_bench.sv
module hms_time_counter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0, tick = 1'b0, hour_mode_24 = 1'b1, load = 1'b0, irq_clr = 1'b0;
  logic [31:0] load_word = '0;
  logic [31:0] time_q;
  logic        wrap_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int mh = 0, mm = 0, ms = 0, mf = 0;
  bit mirq = 0;

  always #5 clk = ~clk;

  hms_time_counter u_hms_time_counter (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .hour_mode_24(hour_mode_24),
    .load(load), .load_word(load_word), .irq_clr(irq_clr),
    .time_q(time_q), .wrap_irq(wrap_irq)
  );

  function automatic int clampv(int v, int top);
    return (v > top) ? top : v;
  endfunction

  always @(posedge clk) begin
    int lim;
    bit wrapped;
    lim = hour_mode_24 ? 23 : 255;
    wrapped = 0;
    if (rst) begin
      mh = 0; mm = 0; ms = 0; mf = 0; mirq = 0;
    end else begin
      if (load) begin
        mf = load_word[6:0];
        ms = clampv(int'(load_word[13:8]), 59);
        mm = clampv(int'(load_word[21:16]), 59);
        mh = clampv(int'(load_word[31:24]), lim);
      end else if (en && tick) begin
        if (mf < 127) mf++;
        else begin
          mf = 0;
          if (ms < 59) ms++;
          else begin
            ms = 0;
            if (mm < 59) mm++;
            else begin
              mm = 0;
              if (mh >= lim) begin mh = 0; wrapped = 1; end
              else mh++;
            end
          end
        end
      end
      if (wrapped) mirq = 1;
      else if (irq_clr) mirq = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, field by field
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(time_q[6:0]   == 7'(mf), "R1 fraction", 32'(time_q[6:0]), 32'(mf));
      chk(time_q[13:8]  == 6'(ms), "R2 seconds",  32'(time_q[13:8]), 32'(ms));
      chk(time_q[21:16] == 6'(mm), "R3 minutes",  32'(time_q[21:16]), 32'(mm));
      chk(time_q[31:24] == 8'(mh), "R4 hours",    32'(time_q[31:24]), 32'(mh));
      chk({time_q[23:22], time_q[15:14], time_q[7]} == 5'b0, "R5 reserved",
          32'({time_q[23:22], time_q[15:14], time_q[7]}), 32'd0);
      chk(wrap_irq == mirq, "R8 wrap flag", 32'(wrap_irq), 32'(mirq));
    end
  end

  task automatic drive(input bit e, input bit t, input bit l, input logic [31:0] w, input bit c);
    @(negedge clk); #1;
    en = e; tick = t; load = l; load_word = w; irq_clr = c;
  endtask

  task automatic settle();
    @(negedge clk); #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst = 1'b0;
    settle();
    chk(time_q == 32'd0, "R9 reset time", time_q, 32'd0);
    chk(wrap_irq == 1'b0, "R9 reset flag", 32'(wrap_irq), 32'd0);

    // 200 qualified ticks: 1 s and 72/128
    for (int i = 0; i < 200; i++) drive(1, 1, 0, '0, 0);
    drive(1, 0, 0, '0, 0);
    settle();
    chk(time_q == 32'h0000_0148, "R2 carry from fraction", time_q, 32'h0000_0148);

    // R6: disabled ticks and enabled non-ticks
    for (int i = 0; i < 8; i++) drive(0, 1, 0, '0, 0);
    for (int i = 0; i < 8; i++) drive(1, 0, 0, '0, 0);
    settle();
    chk(time_q == 32'h0000_0148, "R6 hold without qualified tick", time_q, 32'h0000_0148);

    // R4/R8: 23:59:59:126 in 24-hour mode, two ticks -> 0 and flag
    hour_mode_24 = 1'b1;
    drive(0, 0, 1, 32'h173B_3B7E, 0);
    drive(1, 1, 0, '0, 0);
    drive(1, 1, 0, '0, 0);
    drive(0, 0, 0, '0, 0);
    settle();
    chk(time_q == 32'd0, "R4 day wrap", time_q, 32'd0);
    chk(wrap_irq == 1'b1, "R8 flag set", 32'(wrap_irq), 32'd1);
    repeat (3) drive(1, 0, 0, '0, 0);
    settle();
    chk(wrap_irq == 1'b1, "R8 flag sticky", 32'(wrap_irq), 32'd1);
    drive(0, 0, 0, '0, 1);
    drive(0, 0, 0, '0, 0);
    settle();
    chk(wrap_irq == 1'b0, "R8 flag cleared", 32'(wrap_irq), 32'd0);

    // R7: clamp in both hour modes, reserved dropped
    drive(0, 0, 1, 32'hFFFF_FFFF, 0);
    drive(0, 0, 0, '0, 0);
    settle();
    chk(time_q == 32'h173B_3B7F, "R7 clamp 24h", time_q, 32'h173B_3B7F);
    drive(0, 0, 0, '0, 0); hour_mode_24 = 1'b0;
    drive(0, 0, 1, 32'hFFFF_FFFF, 0);
    drive(0, 0, 0, '0, 0);
    settle();
    chk(time_q == 32'hFF3B_3B7F, "R7 clamp 256h", time_q, 32'hFF3B_3B7F);
    // R4/R8: 256-hour wrap with clear in same cycle -> wrap wins
    drive(1, 1, 0, '0, 1);
    drive(0, 0, 0, '0, 0);
    settle();
    chk(time_q == 32'd0, "R4 full wrap", time_q, 32'd0);
    chk(wrap_irq == 1'b1, "R8 wrap beats clear", 32'(wrap_irq), 32'd1);
    drive(0, 0, 0, '0, 1);

    // R7: load has priority over a tick
    drive(1, 1, 1, 32'h0102_0304, 0);
    drive(0, 0, 0, '0, 0);
    settle();
    chk(time_q == 32'h0102_0304, "R7 load over tick", time_q, 32'h0102_0304);

    // R4: hour above day limit after mode change wraps to 0
    drive(0, 0, 1, 32'h303B_3B7F, 0);
    drive(0, 0, 0, '0, 0); hour_mode_24 = 1'b1;
    drive(1, 1, 0, '0, 0);
    drive(0, 0, 0, '0, 0);
    settle();
    chk(time_q == 32'd0, "R4 above limit wraps", time_q, 32'd0);

    // pseudo-random traffic, compared against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      logic [31:0] w;
      r = $urandom;
      w = (r[3:0] == 0) ? $urandom : {8'(r[4] ? 23 : 255), 8'h3B, 8'h3B, 1'b0, r[14:8]};
      if (r[23:20] == 0) hour_mode_24 = r[24];
      drive(r[16] | r[17], r[18] | r[19], r[31:26] == 0, w, r[25:21] == 0);
    end
    drive(0, 0, 0, '0, 0);
    settle();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule